// File: doc/BRIEF.md
# Debug Breakpoint Address Matcher

This block watches the stream of memory and I/O accesses of a core and signals when an access touches one of four programmed breakpoints. Software loads four breakpoint address registers and one control register through a simple register port. Each breakpoint has an enable bit, a 2-bit access-type code and a 2-bit length code. A mode flag in the control register selects between a basic type decoding and an extended decoding that adds I/O breakpoints.

Each access arrives with a strobe, its address, an encoded byte size and its kind: instruction fetch, data read, data write or I/O. In the same cycle the block drives a per-breakpoint hit vector. Each hit is also captured into a 4-bit sticky status register, which software reads and clears by writing zero to the bits it wants cleared.

The length code masks off low address bits, so a breakpoint always covers a naturally aligned range of 1, 2, 4 or, when a build option allows it, 8 bytes. A data access hits when any of its bytes falls inside that range. An I/O port address is zero-extended before it is compared.

Top module: `dbg_bp_matcher`

## Requirements
- R1: After reset every register reads zero. Register offset 0 to 3 are breakpoint addresses 0 to 3, offset 4 is control and offset 5 is status. A write to offset 0 to 4 reads back unchanged on the next cycle. `reg_rdata` is combinational from `reg_addr`.
- R2: Control layout: bit n enables breakpoint n, bit 8 is the extension flag, bits 17+4n:16+4n hold the type code of breakpoint n and bits 19+4n:18+4n hold its length code.
- R3: With the extension flag clear, type 00 matches instruction fetches only, 01 matches data writes only, 11 matches data reads and data writes but not fetches, and 10 never hits.
- R4: With the extension flag set, type 10 matches I/O accesses (kind 11), type 11 still matches only data reads and data writes, and types 00 and 01 decode as in R3.
- R5: Length 00 covers 1 byte, 01 covers 2 bytes with address bit 0 ignored, and 11 covers 4 bytes with bits 1:0 ignored. Length 10 never hits unless the parameter EN_8B is set, and then it covers 8 bytes with bits 2:0 ignored.
- R6: An access with size code s (00=1, 01=2, 10=4, 11=8 bytes) touches bytes addr to addr+2^s-1. Access kinds are 00 fetch, 01 data read, 10 data write and 11 I/O. A data or I/O breakpoint hits when any touched byte lies in its masked range.
- R7: For I/O accesses only `acc_addr[15:0]` is used, zero-extended to the address width. The upper access bits are ignored, and a breakpoint address with any upper bit set never matches an I/O access.
- R8: A fetch breakpoint hits only on a fetch whose address equals the breakpoint address exactly, and only with length 00. Any other length gives no hit.
- R9: `hit_vec` is valid in the cycle of the access. It is zero while `acc_valid` is low, and a breakpoint whose enable bit is clear never hits.
- R10: A hit sets its status bit one cycle after the strobe. The bit stays set until a write to status carries 0 in that position, and writing 1 leaves it alone. A hit in the same cycle as a clear wins. Status bits of disabled breakpoints can still be read and cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset for write and read |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| acc_valid | input | 1 | Access strobe |
| acc_kind | input | 2 | Access kind: 00 fetch, 01 data read, 10 data write, 11 I/O |
| acc_addr | input | 32 | Access address (I/O uses bits 15:0) |
| acc_size | input | 2 | Access size code: 1, 2, 4 or 8 bytes |
| hit_vec | output | 4 | Per-breakpoint hit in the access cycle |

## Verification
The bench targets the edges of the masked ranges. These are a misaligned breakpoint address that must snap down, accesses that end one byte short of a range, and multi-byte accesses that start before a range and run into it. A matcher that compared only start addresses, or forgot to mask, misses these hits or reports false ones. It also drives the undefined type and length codes, fetch breakpoints with non-zero length, and I/O accesses whose upper address bits are set, where a wrong design fires a hit. Finally it clears status in the same cycle as a new hit, where a wrong priority loses the event.

// File: rtl/dbg_bp_pkg.sv
package dbg_bp_pkg;

   typedef enum logic [1:0] {
      ACC_FETCH = 2'b00,
      ACC_DRD   = 2'b01,
      ACC_DWR   = 2'b10,
      ACC_IO    = 2'b11
   } acc_kind_e;

   localparam int CTRL_W       = 32;
   localparam int CTRL_EXT_BIT = 8;
   localparam int RA_W         = 3;
   localparam logic [RA_W-1:0] RA_CTRL = 3'd4;
   localparam logic [RA_W-1:0] RA_STAT = 3'd5;

   function automatic int type_lsb(input int n);
      return 16 + 4 * n;
   endfunction

   function automatic int len_lsb(input int n);
      return 18 + 4 * n;
   endfunction

endpackage

// File: rtl/dbg_bp_unit.sv
module dbg_bp_unit
   import dbg_bp_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int IO_W   = 16,
   parameter bit EN_8B  = 1'b0
) (
   input  logic              en,
   input  logic              ext,
   input  logic [1:0]        bp_type,
   input  logic [1:0]        bp_len,
   input  logic [ADDR_W-1:0] bp_addr,
   input  logic              acc_valid,
   input  logic [1:0]        acc_kind,
   input  logic [ADDR_W-1:0] acc_addr,
   input  logic [1:0]        acc_size,
   output logic              hit
);

   logic [1:0]        mask_bits;
   logic              len_ok;
   logic [ADDR_W-1:0] low_mask;
   logic [ADDR_W-1:0] rng_lo;
   logic [ADDR_W-1:0] rng_hi;
   logic [ADDR_W-1:0] eff_addr;
   logic [3:0]        span;
   logic [ADDR_W:0]   acc_end;
   logic              overlap;
   logic              exec_hit;
   logic              data_sel;
   acc_kind_e         kind;

   assign kind = acc_kind_e'(acc_kind);

   always_comb begin
      case (bp_len)
         2'b00:   begin mask_bits = 2'd0; len_ok = 1'b1;  end
         2'b01:   begin mask_bits = 2'd1; len_ok = 1'b1;  end
         2'b11:   begin mask_bits = 2'd2; len_ok = 1'b1;  end
         default: begin mask_bits = 2'd3; len_ok = EN_8B; end
      endcase
   end

   assign low_mask = ~({ADDR_W{1'b1}} << mask_bits);
   assign rng_lo   = bp_addr & ~low_mask;
   assign rng_hi   = rng_lo | low_mask;

   generate
      if (ADDR_W > IO_W) begin : g_io_ext
         assign eff_addr = (kind == ACC_IO) ?
                           {{(ADDR_W-IO_W){1'b0}}, acc_addr[IO_W-1:0]} : acc_addr;
      end else begin : g_io_full
         assign eff_addr = acc_addr;
      end
   endgenerate

   assign span    = ~(4'b1111 << acc_size);
   assign acc_end = {1'b0, eff_addr} + (ADDR_W+1)'(span);
   assign overlap = ({1'b0, eff_addr} <= {1'b0, rng_hi}) &&
                    ({1'b0, rng_lo} <= acc_end);

   always_comb begin
      exec_hit = 1'b0;
      data_sel = 1'b0;
      case (bp_type)
         2'b00: exec_hit = (kind == ACC_FETCH) && (bp_len == 2'b00) &&
                           (acc_addr == bp_addr);
         2'b01: data_sel = (kind == ACC_DWR);
         2'b10: data_sel = ext && (kind == ACC_IO);
         default: data_sel = (kind == ACC_DRD) || (kind == ACC_DWR);
      endcase
   end

   assign hit = acc_valid && en && (exec_hit || (data_sel && len_ok && overlap));

endmodule

// File: rtl/dbg_bp_regfile.sv
module dbg_bp_regfile
   import dbg_bp_pkg::*;
#(
   parameter int NUM_BP = 4,
   parameter int ADDR_W = 32
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     wr_en,
   input  logic [RA_W-1:0]          addr,
   input  logic [ADDR_W-1:0]        wdata,
   input  logic [NUM_BP-1:0]        status,
   output logic [ADDR_W-1:0]        rdata,
   output logic [CTRL_W-1:0]        ctrl,
   output logic [NUM_BP*ADDR_W-1:0] bp_addr_flat
);

   logic [CTRL_W-1:0] ctrl_q;

   always_ff @(posedge clk) begin
      if (!rst_n)                        ctrl_q <= '0;
      else if (wr_en && addr == RA_CTRL) ctrl_q <= wdata[CTRL_W-1:0];
   end

   assign ctrl = ctrl_q;

   generate
      for (genvar i = 0; i < NUM_BP; i++) begin : g_bp
         logic [ADDR_W-1:0] addr_q;
         always_ff @(posedge clk) begin
            if (!rst_n)                             addr_q <= '0;
            else if (wr_en && addr == RA_W'(i))     addr_q <= wdata;
         end
         assign bp_addr_flat[i*ADDR_W +: ADDR_W] = addr_q;
      end
   endgenerate

   always_comb begin
      rdata = '0;
      if (addr == RA_CTRL)          rdata = ADDR_W'(ctrl_q);
      else if (addr == RA_STAT)     rdata = ADDR_W'(status);
      else if (int'(addr) < NUM_BP) rdata = bp_addr_flat[int'(addr)*ADDR_W +: ADDR_W];
   end

endmodule

// File: rtl/dbg_bp_status.sv
module dbg_bp_status #(
   parameter int NUM_BP = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_BP-1:0] hit,
   input  logic              clr_we,
   input  logic [NUM_BP-1:0] keep_mask,
   output logic [NUM_BP-1:0] status
);

   logic [NUM_BP-1:0] status_q;

   always_ff @(posedge clk) begin
      if (!rst_n) status_q <= '0;
      else        status_q <= (clr_we ? (status_q & keep_mask) : status_q) | hit;
   end

   assign status = status_q;

endmodule

// File: rtl/dbg_bp_matcher.sv
module dbg_bp_matcher
   import dbg_bp_pkg::*;
#(
   parameter int NUM_BP = 4,
   parameter int ADDR_W = 32,
   parameter int IO_W   = 16,
   parameter bit EN_8B  = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr_en,
   input  logic [2:0]        reg_addr,
   input  logic [ADDR_W-1:0] reg_wdata,
   output logic [ADDR_W-1:0] reg_rdata,
   input  logic              acc_valid,
   input  logic [1:0]        acc_kind,
   input  logic [ADDR_W-1:0] acc_addr,
   input  logic [1:0]        acc_size,
   output logic [NUM_BP-1:0] hit_vec
);

   generate
      if (NUM_BP != 4) begin : g_bad_num
         $error("dbg_bp_matcher: control layout fixes NUM_BP at 4");
      end
      if (ADDR_W < CTRL_W) begin : g_bad_addr
         $error("dbg_bp_matcher: ADDR_W must be at least the control width");
      end
      if (IO_W < 1 || IO_W > ADDR_W) begin : g_bad_io
         $error("dbg_bp_matcher: IO_W out of range");
      end
   endgenerate

   logic [CTRL_W-1:0]        ctrl_q;
   logic [NUM_BP-1:0]        status_q;
   logic [NUM_BP*ADDR_W-1:0] bp_addr_flat;
   logic                     stat_wr;

   assign stat_wr = reg_wr_en && (reg_addr == RA_STAT);

   dbg_bp_regfile #(.NUM_BP(NUM_BP), .ADDR_W(ADDR_W)) u_regs (
      .clk          (clk),
      .rst_n        (rst_n),
      .wr_en        (reg_wr_en),
      .addr         (reg_addr),
      .wdata        (reg_wdata),
      .status       (status_q),
      .rdata        (reg_rdata),
      .ctrl         (ctrl_q),
      .bp_addr_flat (bp_addr_flat)
   );

   generate
      for (genvar i = 0; i < NUM_BP; i++) begin : g_unit
         dbg_bp_unit #(.ADDR_W(ADDR_W), .IO_W(IO_W), .EN_8B(EN_8B)) u_unit (
            .en        (ctrl_q[i]),
            .ext       (ctrl_q[CTRL_EXT_BIT]),
            .bp_type   (ctrl_q[type_lsb(i) +: 2]),
            .bp_len    (ctrl_q[len_lsb(i) +: 2]),
            .bp_addr   (bp_addr_flat[i*ADDR_W +: ADDR_W]),
            .acc_valid (acc_valid),
            .acc_kind  (acc_kind),
            .acc_addr  (acc_addr),
            .acc_size  (acc_size),
            .hit       (hit_vec[i])
         );
      end
   endgenerate

   dbg_bp_status #(.NUM_BP(NUM_BP)) u_status (
      .clk       (clk),
      .rst_n     (rst_n),
      .hit       (hit_vec),
      .clr_we    (stat_wr),
      .keep_mask (reg_wdata[NUM_BP-1:0]),
      .status    (status_q)
   );

endmodule

// File: rtl/dbg_bp_checker.sv
module dbg_bp_checker #(
   parameter int NUM_BP = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              acc_valid,
   input logic [NUM_BP-1:0] hit_vec,
   input logic [31:0]       ctrl,
   input logic [NUM_BP-1:0] status,
   input logic              reg_wr_en,
   input logic [2:0]        reg_addr,
   input logic [NUM_BP-1:0] wlow
);

   logic stat_wr;
   assign stat_wr = reg_wr_en && (reg_addr == 3'd5);

   p_idle_no_hit_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !acc_valid |-> (hit_vec == '0));

   generate
      for (genvar i = 0; i < NUM_BP; i++) begin : g_chk
         p_disabled_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
            !ctrl[i] |-> !hit_vec[i]);
         p_undef_type_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (!ctrl[8] && ctrl[16+4*i +: 2] == 2'b10) |-> !hit_vec[i]);
         p_exec_len_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (ctrl[16+4*i +: 2] == 2'b00 && ctrl[18+4*i +: 2] != 2'b00) |-> !hit_vec[i]);
         p_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
            hit_vec[i] |=> status[i]);
         p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
            (status[i] && !(stat_wr && !wlow[i])) |=> status[i]);
         p_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
            (status[i] && stat_wr && !wlow[i] && !hit_vec[i]) |=> !status[i]);
         p_no_spurious_r10: assert property (@(posedge clk) disable iff (!rst_n)
            (!status[i] && !hit_vec[i]) |=> !status[i]);
      end
   endgenerate

endmodule

bind dbg_bp_matcher dbg_bp_checker #(.NUM_BP(NUM_BP)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .acc_valid (acc_valid),
   .hit_vec   (hit_vec),
   .ctrl      (ctrl_q),
   .status    (status_q),
   .reg_wr_en (reg_wr_en),
   .reg_addr  (reg_addr),
   .wlow      (reg_wdata[NUM_BP-1:0])
);

// File: tb/tb_dbg_bp_matcher.sv
module tb_dbg_bp_matcher;

   localparam int CLK_P = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr_en = 1'b0;
   logic [2:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        acc_valid = 1'b0;
   logic [1:0]  acc_kind = '0;
   logic [31:0] acc_addr = '0;
   logic [1:0]  acc_size = '0;
   logic [3:0]  hit_vec;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   localparam logic [1:0] K_F = 2'b00, K_R = 2'b01, K_W = 2'b10, K_IO = 2'b11;

   always #(CLK_P/2) clk = ~clk;

   dbg_bp_matcher dut (
      .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .acc_valid(acc_valid),
      .acc_kind(acc_kind), .acc_addr(acc_addr), .acc_size(acc_size), .hit_vec(hit_vec)
   );

   function automatic logic [31:0] mk_ctrl(input logic ext, input logic [3:0] en,
                                           input logic [7:0] types, input logic [7:0] lens);
      logic [31:0] c = '0;
      c[3:0] = en;
      c[8]   = ext;
      for (int i = 0; i < 4; i++) begin
         c[16+4*i +: 2] = types[2*i +: 2];
         c[18+4*i +: 2] = lens[2*i +: 2];
      end
      return c;
   endfunction

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr_en = 1'b0;
   endtask

   task automatic rd_check(input string tag, input logic [2:0] a, input logic [31:0] exp);
      @(negedge clk);
      reg_addr = a;
      #1 check(tag, reg_rdata, exp);
   endtask

   task automatic acc(input string tag, input logic [1:0] k, input logic [31:0] a,
                      input logic [1:0] s, input logic [3:0] exp);
      @(negedge clk);
      acc_valid = 1'b1; acc_kind = k; acc_addr = a; acc_size = s;
      #1 check(tag, {28'd0, hit_vec}, {28'd0, exp});
      @(negedge clk);
      acc_valid = 1'b0;
   endtask

   task automatic t_reset();
      for (int a = 0; a < 6; a++) rd_check("R1 reset value", 3'(a), 32'd0);
   endtask

   task automatic t_regs();
      wr(3'd0, 32'hDEAD_BEE0); wr(3'd3, 32'h1234_5678);
      wr(3'd4, 32'hA5A5_0123);
      rd_check("R1 addr0 readback", 3'd0, 32'hDEAD_BEE0);
      rd_check("R1 addr3 readback", 3'd3, 32'h1234_5678);
      rd_check("R2 ctrl readback", 3'd4, 32'hA5A5_0123);
   endtask

   task automatic t_legacy();
      wr(3'd0, 32'h1000); wr(3'd1, 32'h2000); wr(3'd2, 32'h3000); wr(3'd3, 32'h4000);
      wr(3'd4, mk_ctrl(1'b0, 4'hF, {2'b10, 2'b11, 2'b01, 2'b00}, {2'b11, 2'b11, 2'b11, 2'b00}));
      acc("R3 fetch on exec bp",          K_F, 32'h1000, 2'd0, 4'b0001);
      acc("R3 write on write bp",         K_W, 32'h2000, 2'd0, 4'b0010);
      acc("R3 read ignored by write bp",  K_R, 32'h2000, 2'd0, 4'b0000);
      acc("R3 read on r/w bp",            K_R, 32'h3002, 2'd0, 4'b0100);
      acc("R3 fetch ignored by r/w bp",   K_F, 32'h3000, 2'd0, 4'b0000);
      acc("R3 undefined type 10 write",   K_W, 32'h4000, 2'd0, 4'b0000);
      acc("R3 undefined type 10 io",      K_IO, 32'h4000, 2'd0, 4'b0000);
   endtask

   task automatic t_ext();
      wr(3'd4, mk_ctrl(1'b1, 4'hF, {2'b10, 2'b11, 2'b01, 2'b00}, {2'b11, 2'b11, 2'b11, 2'b00}));
      acc("R4 io hit on type 10",          K_IO, 32'h4002, 2'd0, 4'b1000);
      acc("R4 data write misses type 10",  K_W, 32'h4000, 2'd0, 4'b0000);
      acc("R4 read on type 11",            K_R, 32'h3000, 2'd0, 4'b0100);
      acc("R4 io misses type 11 and 00",   K_IO, 32'h3000, 2'd0, 4'b0000);
      acc("R4 fetch still on type 00",     K_F, 32'h1000, 2'd0, 4'b0001);
      wr(3'd3, 32'h0001_4000);
      acc("R7 upper bp bits block io",     K_IO, 32'hFFFF_4000, 2'd0, 4'b0000);
      wr(3'd3, 32'h4000);
      acc("R7 upper access bits ignored",  K_IO, 32'hABCD_4001, 2'd0, 4'b1000);
   endtask

   task automatic t_len();
      wr(3'd0, 32'h2003); wr(3'd1, 32'h5000); wr(3'd2, 32'h6003);
      wr(3'd4, mk_ctrl(1'b0, 4'b0111, {2'b00, 2'b11, 2'b11, 2'b11}, {2'b00, 2'b11, 2'b10, 2'b01}));
      acc("R5 2-byte masked low byte",  K_R, 32'h2002, 2'd0, 4'b0001);
      acc("R5 2-byte below range",      K_R, 32'h2001, 2'd0, 4'b0000);
      acc("R5 2-byte above range",      K_R, 32'h2004, 2'd0, 4'b0000);
      acc("R5 length 10 undefined",     K_R, 32'h5000, 2'd0, 4'b0000);
      acc("R5 4-byte snaps down",       K_W, 32'h6000, 2'd0, 4'b0100);
      acc("R6 4B access runs into rng", K_R, 32'h5FFE, 2'd2, 4'b0100);
      acc("R6 4B access ends short",    K_R, 32'h5FFC, 2'd2, 4'b0000);
      acc("R6 8B access from last byte",K_R, 32'h6003, 2'd3, 4'b0100);
      acc("R6 8B access ends short",    K_R, 32'h5FF8, 2'd3, 4'b0000);
      acc("R6 2B access inside",        K_W, 32'h6002, 2'd1, 4'b0100);
      acc("R6 4B access covers 2B bp",  K_R, 32'h2000, 2'd2, 4'b0001);
   endtask

   task automatic t_exec();
      wr(3'd0, 32'h1000);
      wr(3'd4, mk_ctrl(1'b0, 4'b0001, 8'h00, {6'd0, 2'b01}));
      acc("R8 exec with len 01 no hit", K_F, 32'h1000, 2'd0, 4'b0000);
      wr(3'd4, mk_ctrl(1'b0, 4'b0001, 8'h00, 8'h00));
      acc("R8 exec exact address",      K_F, 32'h1000, 2'd0, 4'b0001);
      acc("R8 exec next byte no hit",   K_F, 32'h1001, 2'd0, 4'b0000);
      acc("R8 exec ignores data read",  K_R, 32'h1000, 2'd0, 4'b0000);
   endtask

   task automatic t_disabled();
      wr(3'd4, mk_ctrl(1'b0, 4'b0000, 8'h00, 8'h00));
      acc("R9 disabled bp quiet", K_F, 32'h1000, 2'd0, 4'b0000);
      wr(3'd4, mk_ctrl(1'b0, 4'b0001, 8'h00, 8'h00));
      @(negedge clk);
      acc_valid = 1'b0; acc_kind = K_F; acc_addr = 32'h1000; acc_size = 2'd0;
      #1 check("R9 no strobe no hit", {28'd0, hit_vec}, 32'd0);
   endtask

   task automatic t_status();
      wr(3'd0, 32'h1000); wr(3'd1, 32'h2000);
      wr(3'd4, mk_ctrl(1'b0, 4'b0011, {4'd0, 2'b01, 2'b00}, 8'h00));
      wr(3'd5, 32'h0);
      rd_check("R10 status cleared", 3'd5, 32'h0);
      acc("R10 exec hit", K_F, 32'h1000, 2'd0, 4'b0001);
      rd_check("R10 status set after hit", 3'd5, 32'h1);
      repeat (3) @(negedge clk);
      rd_check("R10 status sticky", 3'd5, 32'h1);
      acc("R10 write hit", K_W, 32'h2000, 2'd0, 4'b0010);
      rd_check("R10 two bits set", 3'd5, 32'h3);
      wr(3'd5, 32'h1);
      rd_check("R10 write-zero clears, one keeps", 3'd5, 32'h1);
      wr(3'd5, 32'h0);
      @(negedge clk);
      reg_wr_en = 1'b1; reg_addr = 3'd5; reg_wdata = 32'h0;
      acc_valid = 1'b1; acc_kind = K_F; acc_addr = 32'h1000; acc_size = 2'd0;
      @(negedge clk);
      reg_wr_en = 1'b0; acc_valid = 1'b0;
      rd_check("R10 hit wins over clear", 3'd5, 32'h1);
      wr(3'd4, mk_ctrl(1'b0, 4'b0000, 8'h00, 8'h00));
      rd_check("R10 disabled bp status readable", 3'd5, 32'h1);
      wr(3'd5, 32'h0);
      rd_check("R10 disabled bp status clearable", 3'd5, 32'h0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_regs();
      t_legacy();
      t_ext();
      t_len();
      t_exec();
      t_disabled();
      t_status();
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog expired actual=running expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

endmodule